// File: doc/BRIEF.md
# System Interrupt Controller with Wakeup

This block collects level interrupt requests from a group of peripherals and turns them into an interrupt vector for a processor core, plus a wakeup request for a power controller. Each request first crosses into the block's clock domain through a two-flop synchronizer. Then a programmable per-channel table routes it to a channel slot. The slot position is the interrupt ID the request raises, so moving a peripheral to another channel moves its interrupt bit with it. This happens whether or not any transfer engine on that channel is in use.

Three words are visible on a simple register bus: a raw pending word, an enable mask and a wakeup-enable word. One routing entry per channel follows them. The raw pending word is read-only and ignores the mask. The core receives the raw pending bits ANDed with the mask. While the core reports itself idle, any pending bit with its wakeup-enable set latches a wakeup request, and the request holds until the idle input drops. The bus completes every access in the cycle it is presented. There is no handshake and no back-pressure: reads are combinational on the address, and a write lands at the clock edge where `bus_req` and `bus_we` are both high.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Pending bit c reads 1 exactly when the peripheral routed to channel c has its request high. The bit appears two clock edges after the request input changes, and the mask has no influence on it.
- R2: A bus write to address 0 (the pending word) changes nothing; the pending word keeps following the requests.
- R3: `irq_out` equals the pending word ANDed with the mask word at address 1; the mask resets to all zeros.
- R4: Routing entry c sits at address 3+c. Bit IW is a "routed" flag and bits IW-1:0 hold the peripheral index, where IW = clog2(NPERIPH). After reset, entry c routes peripheral c when c < NPERIPH and is cleared otherwise.
- R5: A peripheral routed to channel c raises interrupt bit c, not the bit of its own index.
- R6: When several routed entries name the same peripheral, only the lowest-numbered channel reports it. An entry whose flag is clear or whose index is not below NPERIPH reports 0.
- R7: The wakeup-enable word at address 2 resets to all ones.
- R8: When `core_idle` is high and some pending bit has its wakeup-enable set at a clock edge, `wake_req` is high after that edge. Pending bits whose enable is clear never raise it.
- R9: While `core_idle` is low, `wake_req` is low after every edge, and the wakeup-enable word has no effect.
- R10: Once raised, `wake_req` stays high for as long as `core_idle` stays high, even after the pending bits clear.
- R11: Reads at addresses from 3+NCHAN upward return 0, and unused upper bits of every word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req | input | NPERIPH | Level interrupt requests, one per peripheral |
| core_idle | input | 1 | High while the core is in its idle state |
| bus_req | input | 1 | Access strobe for a write |
| bus_we | input | 1 | Write enable |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_out | output | NCHAN | Masked interrupt vector, bit position = interrupt ID |
| wake_req | output | 1 | Wakeup request to the power controller |

## Verification
The assertions take for granted that `periph_req` and `core_idle` are synchronous to `clk` or already settled at each edge. They also assume that a pending bit can only stem from a request seen two edges earlier, which holds only if the routing table is written while inputs stay level. The stimulus changes every input on the falling edge and holds request patterns for at least two rising edges before it reads them back. Routing rewrites happen through the bus while requests are held at zero, so no assertion window spans a half-finished table.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

  // word addresses; routing entries follow the three control words
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_WAKE   = 2;
  localparam int MAP_BASE    = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_WAKE,
    SEL_MAP
  } reg_sel_e;

endpackage

// File: rtl/irq_wake_sync.sv
module irq_wake_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/irq_wake_route.sv
module irq_wake_route #(
  parameter int NPERIPH = 8,
  parameter int NCHAN   = 8,
  parameter int IW      = 3
) (
  input  logic [NPERIPH-1:0]      req_i,
  input  logic [NCHAN*(IW+1)-1:0] map_i,
  output logic [NCHAN-1:0]        status_o,
  output logic [NCHAN-1:0]        claim_o
);

  localparam int EW = IW + 1;

  logic [EW-1:0] ent;
  logic [EW-1:0] other;
  logic          taken;

  // a channel claims its peripheral unless a lower channel already names it
  always_comb begin
    status_o = '0;
    claim_o  = '0;
    ent      = '0;
    other    = '0;
    taken    = 1'b0;
    for (int c = 0; c < NCHAN; c++) begin
      ent   = map_i[c*EW +: EW];
      taken = 1'b0;
      if (ent[IW] && (32'(ent[IW-1:0]) < NPERIPH)) begin
        for (int j = 0; j < NCHAN; j++) begin
          if (j < c) begin
            other = map_i[j*EW +: EW];
            if (other[IW] && (other[IW-1:0] == ent[IW-1:0])) taken = 1'b1;
          end
        end
        if (!taken) begin
          claim_o[c]  = 1'b1;
          status_o[c] = req_i[ent[IW-1:0]];
        end
      end
    end
  end

endmodule

// File: rtl/irq_wake_regs.sv
module irq_wake_regs
  import irq_wake_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter int NCHAN   = 8,
  parameter int DW      = 32,
  parameter int IW      = 3,
  parameter int AW      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  input  logic [NCHAN-1:0]        status_i,
  output logic [NCHAN-1:0]        mask_o,
  output logic [NCHAN-1:0]        wake_en_o,
  output logic [NCHAN*(IW+1)-1:0] map_o,
  output logic [DW-1:0]           rdata_o
);

  localparam int EW = IW + 1;
  localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1;

  reg_sel_e      sel;
  logic [CW-1:0] map_idx;
  logic          wr;

  assign wr = bus_req && bus_we;

  always_comb begin
    sel     = SEL_NONE;
    map_idx = '0;
    if (32'(bus_addr) == ADDR_STATUS)      sel = SEL_STATUS;
    else if (32'(bus_addr) == ADDR_MASK)   sel = SEL_MASK;
    else if (32'(bus_addr) == ADDR_WAKE)   sel = SEL_WAKE;
    else if (32'(bus_addr) >= MAP_BASE && 32'(bus_addr) < MAP_BASE + NCHAN) begin
      sel     = SEL_MAP;
      map_idx = CW'(32'(bus_addr) - MAP_BASE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o    <= '0;
      wake_en_o <= '1;
    end else if (wr) begin
      if (sel == SEL_MASK) mask_o    <= bus_wdata[NCHAN-1:0];
      if (sel == SEL_WAKE) wake_en_o <= bus_wdata[NCHAN-1:0];
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_map
    localparam logic [EW-1:0] RST_ENT = (c < NPERIPH) ? {1'b1, IW'(c)} : '0;
    logic [EW-1:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q <= RST_ENT;
      else if (wr && sel == SEL_MAP && map_idx == CW'(c)) entry_q <= bus_wdata[EW-1:0];
    end
    assign map_o[c*EW +: EW] = entry_q;
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_STATUS: rdata_o[NCHAN-1:0] = status_i;
      SEL_MASK:   rdata_o[NCHAN-1:0] = mask_o;
      SEL_WAKE:   rdata_o[NCHAN-1:0] = wake_en_o;
      SEL_MAP:    rdata_o[EW-1:0]    = map_o[32'(map_idx)*EW +: EW];
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter int NCHAN   = 8,
  parameter int DW      = 32,
  localparam int IW     = $clog2(NPERIPH),
  localparam int AW     = $clog2(MAP_BASE + NCHAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPERIPH-1:0] periph_req,
  input  logic               core_idle,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NCHAN-1:0]   irq_out,
  output logic               wake_req
);

  localparam int EW = IW + 1;

  logic [NPERIPH-1:0]    req_sync;
  logic [NCHAN-1:0]      raw_status;
  logic [NCHAN-1:0]      claimed;
  logic [NCHAN-1:0]      mask;
  logic [NCHAN-1:0]      wake_en;
  logic [NCHAN*EW-1:0]   route_map;
  logic                  wake_hit;
  logic                  wake_q;

  irq_wake_sync #(.W(NPERIPH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (periph_req),
    .sync_o  (req_sync)
  );

  irq_wake_route #(.NPERIPH(NPERIPH), .NCHAN(NCHAN), .IW(IW)) u_route (
    .req_i    (req_sync),
    .map_i    (route_map),
    .status_o (raw_status),
    .claim_o  (claimed)
  );

  irq_wake_regs #(.NPERIPH(NPERIPH), .NCHAN(NCHAN), .DW(DW), .IW(IW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_i  (raw_status),
    .mask_o    (mask),
    .wake_en_o (wake_en),
    .map_o     (route_map),
    .rdata_o   (bus_rdata)
  );

  assign irq_out  = raw_status & mask;
  assign wake_hit = |(raw_status & wake_en);

  // latched while idle, released as soon as the core leaves idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= core_idle & (wake_q | wake_hit);
  end

  assign wake_req = wake_q;

endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
  parameter int NPERIPH = 8,
  parameter int NCHAN   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPERIPH-1:0] periph_req,
  input logic               core_idle,
  input logic [NCHAN-1:0]   irq_out,
  input logic               wake_req,
  input logic [NCHAN-1:0]   raw_status,
  input logic [NCHAN-1:0]   claimed,
  input logic [NCHAN-1:0]   wake_en
);

  assert_sync_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw_status) |-> $past(|periph_req, 2));

  assert_irq_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~raw_status) == '0);

  assert_claim_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status & ~claimed) == '0);

  assert_wake_prompt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_idle && |(raw_status & wake_en)) |=> wake_req);

  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(core_idle && |(raw_status & wake_en)));

  assert_wake_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> !wake_req);

  assert_wake_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && core_idle) |=> wake_req);

endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.NPERIPH(NPERIPH), .NCHAN(NCHAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .periph_req (periph_req),
  .core_idle  (core_idle),
  .irq_out    (irq_out),
  .wake_req   (wake_req),
  .raw_status (raw_status),
  .claimed    (claimed),
  .wake_en    (wake_en)
);

// File: tb/irq_wake_ctrl_test.sv
`timescale 1ns/1ps
module irq_wake_ctrl_test;

  localparam int NP = 6;
  localparam int NC = 8;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] periph_req = '0;
  logic          core_idle = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NC-1:0] irq_out;
  logic          wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]    mdl_map [NC];
  logic [NC-1:0] mdl_mask;

  always #2 clk = ~clk;

  irq_wake_ctrl #(.NPERIPH(NP), .NCHAN(NC), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .core_idle(core_idle),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic set_req(input logic [NP-1:0] v);
    @(negedge clk);
    periph_req = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NC-1:0] exp_status(input logic [NP-1:0] r);
    logic [NC-1:0] s = '0;
    for (int c = 0; c < NC; c++) begin
      if (mdl_map[c][3] && int'(mdl_map[c][2:0]) < NP) begin
        bit dup = 0;
        for (int j = 0; j < c; j++)
          if (mdl_map[j][3] && mdl_map[j][2:0] == mdl_map[c][2:0]) dup = 1;
        if (!dup && r[mdl_map[c][2:0]]) s[c] = 1'b1;
      end
    end
    return s;
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] d;
    for (int v = 0; v < (1 << NP); v++) begin
      logic [NC-1:0] e;
      set_req(NP'(v));
      e = exp_status(NP'(v));
      bus_read(0, d);
      check(d == {24'd0, e}, {tag, " status"}, d, {24'd0, e});
      check(irq_out == (e & mdl_mask), {tag, " irq_out R3"}, 32'(irq_out), 32'(e & mdl_mask));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NC; c++) mdl_map[c] = (c < NP) ? {1'b1, 3'(c)} : 4'd0;
    mdl_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(irq_out == '0, "R3 reset irq_out", 32'(irq_out), 0);
    check(wake_req == 1'b0, "R9 reset wake_req", 32'(wake_req), 0);
    bus_read(1, d); check(d == 0, "R3 reset mask", d, 0);
    bus_read(2, d); check(d == 32'hFF, "R7 reset wake enable", d, 32'hFF);
    for (int c = 0; c < NC; c++) begin
      bus_read(3 + c, d);
      check(d == 32'(mdl_map[c]), "R4 reset routing entry", d, 32'(mdl_map[c]));
    end
    for (int a = 3 + NC; a < 16; a++) begin
      bus_read(a, d); check(d == 0, "R11 unused address", d, 0);
    end

    // R1 latency: one edge after the change nothing, two edges later the bit
    @(negedge clk); periph_req = 6'b000100;
    @(negedge clk); bus_read(0, d); check(d == 0, "R1 after one edge", d, 0);
    @(negedge clk); bus_read(0, d); check(d == 32'h4, "R1 after two edges", d, 32'h4);
    set_req('0);

    // R1/R3 exhaustive with default routing, mask 0 then a pattern
    sweep("R1 default map");
    mdl_mask = 8'hA5; bus_write(1, 32'hFFFF_FFA5);
    bus_read(1, d); check(d == 32'hA5, "R11 mask upper bits", d, 32'hA5);
    sweep("R3 masked");

    // R2: writes to the pending word are ignored
    set_req('0);
    bus_write(0, 32'hFF);
    bus_read(0, d); check(d == 0, "R2 write ignored idle inputs", d, 0);
    set_req(6'b010101);
    bus_write(0, 32'h0);
    bus_read(0, d); check(d == 32'h15, "R2 write ignored live inputs", d, 32'h15);
    set_req('0);

    // R5 single remap: channel 7 takes peripheral 2, channel 2 released
    mdl_map[7] = 4'b1010; bus_write(3 + 7, 32'hA);
    mdl_map[2] = 4'b0010; bus_write(3 + 2, 32'h2);
    set_req(6'b000100);
    bus_read(0, d); check(d == 32'h80, "R5 peripheral follows channel", d, 32'h80);
    set_req('0);

    // R5/R6 sweeps over routing tables with duplicates and out-of-range entries
    mdl_mask = 8'hFF; bus_write(1, 32'hFF);
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < NC; c++) begin
        logic [3:0] e;
        e = {((c + k) % 5) != 0, 3'((c * k + k) % 8)};
        mdl_map[c] = e;
        bus_write(3 + c, {28'hFFFFFFF, e});
      end
      for (int c = 0; c < NC; c++) begin
        bus_read(3 + c, d);
        check(d == 32'(mdl_map[c]), "R4 routing readback", d, 32'(mdl_map[c]));
      end
      sweep("R6 remap sweep");
      set_req('0);
    end

    // restore default routing, mask off
    for (int c = 0; c < NC; c++) begin
      mdl_map[c] = (c < NP) ? {1'b1, 3'(c)} : 4'd0;
      bus_write(3 + c, 32'(mdl_map[c]));
    end
    mdl_mask = '0; bus_write(1, 0);

    // wakeup per peripheral, enable word on and off
    for (int p = 0; p < NP; p++) begin
      core_idle = 1'b0;
      bus_write(2, 32'(~(8'(1) << p)));
      set_req(NP'(1) << p);
      check(wake_req == 1'b0, "R9 not idle", 32'(wake_req), 0);
      @(negedge clk); core_idle = 1'b1;
      @(negedge clk); @(negedge clk);
      check(wake_req == 1'b0, "R8 disabled source no wake", 32'(wake_req), 0);
      bus_write(2, 32'(8'(1) << p));
      @(negedge clk);
      check(wake_req == 1'b1, "R8 enabled source wakes", 32'(wake_req), 1);
      set_req('0);
      @(negedge clk);
      check(wake_req == 1'b1, "R10 held while idle", 32'(wake_req), 1);
      core_idle = 1'b0;
      @(negedge clk);
      check(wake_req == 1'b0, "R9 released when not idle", 32'(wake_req), 0);
    end

    // prompt rise: idle raised with the source already pending
    bus_write(2, 32'hFF);
    set_req(6'b100000);
    @(negedge clk); core_idle = 1'b1;
    @(negedge clk);
    check(wake_req == 1'b1, "R8 one edge after idle", 32'(wake_req), 1);
    core_idle = 1'b0;
    @(negedge clk);
    bus_write(2, 0); bus_write(2, 32'hFF);
    repeat (3) @(negedge clk);
    check(wake_req == 1'b0, "R9 enable writes no effect", 32'(wake_req), 0);
    check(irq_out == 0, "R3 mask zero hides pending", 32'(irq_out), 0);
    set_req('0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule